// File: doc/BRIEF.md
# Indirect Buffer Access Window with RAM Self-Test

This block lets software reach two internal 24-entry, 64-bit data buffers through a 32-bit register port. One buffer is the read buffer and the other is the write buffer. An index register names the entry and picks the buffer. Two 32-bit data registers carry the low and high halves of the entry. Each indirect transaction is finished by the access to the high half. A write to the low half is only staged. A read of the low half captures the whole entry, so the high half read that follows comes from the same snapshot.

A self-test controller shares the same register port. When software starts it, the controller runs a march over both buffers. It writes and checks alternating 0x55/0xAA byte patterns, first in ascending order and then in descending order. The start bit clears itself when the march ends. Pass flags are then reported per buffer and per 32-bit bank.

Register map, chosen by `reg_sel`: 0 = index/select, 1 = low data, 2 = high data, 3 = self-test control/status.

Top module: `bufwin_port`

## Requirements
- R1: The index register holds the entry index in bits [5:0] and the buffer select in bit 6. Bit 6 set means the write buffer and bit 6 clear means the read buffer. It reads back these 7 bits, with bits [31:7] zero, and is 0 after reset.
- R2: A low-data write only stages its value, and the addressed entry does not change. A high-data write stores {high word, staged low word} into the entry named by the index register.
- R3: The two buffers are separate stores. A write to an index in one buffer leaves the same index in the other buffer unchanged.
- R4: A low-data read returns bits [31:0] of the addressed entry and snapshots all 64 bits. A following high-data read returns bits [63:32] of that snapshot, even if the entry was rewritten in between.
- R5: Index values 24 to 63 are invalid. A read at such an index returns zero, and a high-data write at such an index is discarded.
- R6: Read data appears on `reg_rdata` in the cycle after the cycle in which `reg_rd` is sampled high.
- R7: Writing 1 to control bit 0 starts the self-test. Bit 0 reads 1 for exactly 96 cycles, which is 4 passes over 24 entries, and then clears itself. A start written while the test runs is ignored.
- R8: The status bits are: bit 1 read buffer pass, bit 2 write buffer pass, bit 3 read low bank, bit 4 read high bank, bit 5 write low bank, bit 6 write high bank. All of them read 0 while the test runs and after reset. After a fault-free run they all read 1, so the control register reads 0x7E.
- R9: When the march ends, every entry of both buffers holds 0x5555_5555_5555_5555.
- R10: Data-register writes made while the self-test runs do not reach the buffers, so they cannot spoil its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 low data, 2 high data, 3 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
Distinct 64-bit values go to the same index in both buffers. Reading them back shows whether the select bit is decoded and whether the halves land in the right place. A low-only write followed by a read separates staged data from committed data. A rewrite placed between a low read and a high read separates the snapshot from a live read. Indices 23, 24 and 30 bracket the valid range. The self-test is run with a data write and a second start injected mid-march. Its status word and the final buffer contents then show whether the march is isolated from bus writes and whether it ends on the stated pattern.

// File: rtl/bufwin_port.sv
module bufwin_port #(
  parameter int DEPTH = 24,
  parameter int IW    = 6,
  parameter int DW    = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] PAT = {(DW/2){2'b01}};
  localparam logic [1:0] S_IDX = 2'd0, S_LO = 2'd1, S_HI = 2'd2, S_CTL = 2'd3;

  logic [DW-1:0] rbuf [DEPTH];
  logic [DW-1:0] wbuf [DEPTH];
  logic [IW-1:0] idx;
  logic          bsel;
  logic [HW-1:0] stage;
  logic [DW-1:0] snap;
  logic          busy;
  logic [1:0]    phase;
  logic [PW-1:0] ptr;
  logic [3:0]    fail_q;
  logic [5:0]    pass;

  wire           valid = idx < IW'(DEPTH);
  wire [PW-1:0]  eidx  = idx[PW-1:0];
  wire [DW-1:0]  ent   = !valid ? '0 : (bsel ? wbuf[eidx] : rbuf[eidx]);
  wire           start = reg_wr && reg_sel == S_CTL && reg_wdata[0] && !busy;
  wire           commit = reg_wr && reg_sel == S_HI && valid && !busy;

  wire [PW-1:0]  ba    = phase[1] ? PW'(DEPTH - 1) - ptr : ptr;
  wire [DW-1:0]  expv  = (phase == 2'd2) ? ~PAT : PAT;
  wire [DW-1:0]  wrv   = (phase == 2'd1) ? ~PAT : PAT;
  wire           chk   = busy && phase != 2'd0;
  wire [3:0]     fail_now = chk ? {wbuf[ba][DW-1:HW] != expv[DW-1:HW],
                                   wbuf[ba][HW-1:0]  != expv[HW-1:0],
                                   rbuf[ba][DW-1:HW] != expv[DW-1:HW],
                                   rbuf[ba][HW-1:0]  != expv[HW-1:0]} : 4'b0;
  wire [3:0]     fail_all = fail_q | fail_now;
  wire           last = ptr == PW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (busy && phase != 2'd3) begin
      rbuf[ba] <= wrv;
      wbuf[ba] <= wrv;
    end else if (commit) begin
      if (bsel) wbuf[eidx] <= {reg_wdata, stage};
      else      rbuf[eidx] <= {reg_wdata, stage};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; bsel <= 1'b0; stage <= '0; snap <= '0; reg_rdata <= '0;
      busy <= 1'b0; phase <= '0; ptr <= '0; fail_q <= '0; pass <= '0;
    end else begin
      if (reg_wr && reg_sel == S_IDX) begin
        idx  <= reg_wdata[IW-1:0];
        bsel <= reg_wdata[IW];
      end
      if (reg_wr && reg_sel == S_LO) stage <= reg_wdata;
      if (reg_rd) begin
        case (reg_sel)
          S_IDX:   reg_rdata <= 32'({bsel, idx});
          S_LO:    begin reg_rdata <= ent[HW-1:0]; snap <= ent; end
          S_HI:    reg_rdata <= snap[DW-1:HW];
          default: reg_rdata <= 32'({pass, busy});
        endcase
      end
      if (start) begin
        busy <= 1'b1; phase <= '0; ptr <= '0; fail_q <= '0; pass <= '0;
      end else if (busy) begin
        fail_q <= fail_all;
        ptr    <= last ? '0 : ptr + 1'b1;
        if (last) begin
          phase <= phase + 1'b1;
          if (phase == 2'd3) begin
            busy <= 1'b0;
            pass <= {~fail_all[3], ~fail_all[2], ~fail_all[1], ~fail_all[0],
                     ~|fail_all[3:2], ~|fail_all[1:0]};
          end
        end
      end
    end
  end

  a_r8_pass_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pass == '0);
  a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_sel == S_CTL && reg_wdata[0]));
  a_r5_invalid_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == S_LO && !valid) |=> reg_rdata == '0);
  a_r4_hi_read_keeps_snap: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == S_HI) |=> $stable(snap));
  a_r1_idx_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == S_IDX) |=> reg_rdata[31:IW+1] == '0);
endmodule

// File: tb/bufwin_port_test.sv
module bufwin_port_test;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bufwin_port uut (.clk, .rst_n, .reg_wr, .reg_rd, .reg_sel, .reg_wdata, .reg_rdata);

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_sel = s;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic sel, input int i, input logic [63:0] v);
    wr(2'd0, {25'd0, sel, 6'(i)}); wr(2'd1, v[31:0]); wr(2'd2, v[63:32]);
  endtask

  task automatic get(input logic sel, input int i, output logic [63:0] v);
    logic [31:0] lo, hi;
    wr(2'd0, {25'd0, sel, 6'(i)}); rd(2'd1, lo); rd(2'd2, hi); v = {hi, lo};
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); chk("R1 reset index", d, 0);
    rd(2'd3, d); chk("R8 reset status", d, 0);
  endtask

  task automatic t_index;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFD5); rd(2'd0, d); chk("R1 index readback", d, 32'h55);
  endtask

  task automatic t_stage_commit;
    logic [63:0] v;
    put(1'b0, 5, 64'h1111_2222_3333_4444);
    wr(2'd1, 32'hCAFE_F00D);
    get(1'b0, 5, v);
    chk("R2 low staged lo", v[31:0], 32'h3333_4444);
    chk("R2 low staged hi", v[63:32], 32'h1111_2222);
    wr(2'd0, 32'd5); wr(2'd1, 32'hCAFE_F00D); wr(2'd2, 32'hBEEF_0001);
    get(1'b0, 5, v);
    chk("R2 commit lo", v[31:0], 32'hCAFE_F00D);
    chk("R2 commit hi", v[63:32], 32'hBEEF_0001);
  endtask

  task automatic t_separate;
    logic [63:0] v;
    put(1'b1, 5, 64'hAAAA_0000_BBBB_1111);
    get(1'b0, 5, v); chk("R3 read buffer kept", v[31:0], 32'hCAFE_F00D);
    get(1'b1, 5, v); chk("R3 write buffer lo", v[31:0], 32'hBBBB_1111);
    chk("R3 write buffer hi", v[63:32], 32'hAAAA_0000);
  endtask

  task automatic t_snapshot;
    logic [31:0] lo, hi;
    put(1'b1, 7, 64'h7777_0007_7777_1007);
    rd(2'd1, lo);
    wr(2'd1, 32'h0); wr(2'd2, 32'h9999_9999);
    rd(2'd2, hi);
    chk("R4 snapshot lo", lo, 32'h7777_1007);
    chk("R4 snapshot hi", hi, 32'h7777_0007);
    rd(2'd1, lo); chk("R4 new entry lo", lo, 32'h0);
  endtask

  task automatic t_invalid;
    logic [63:0] v;
    put(1'b0, 23, 64'h2323_2323_2323_2323);
    get(1'b0, 23, v); chk("R5 last valid index", v[63:32], 32'h2323_2323);
    put(1'b0, 24, 64'h1234_5678_9ABC_DEF0);
    get(1'b0, 24, v); chk("R5 index 24 reads zero", v[31:0], 0);
    put(1'b1, 30, 64'h1234_5678_9ABC_DEF0);
    get(1'b1, 30, v); chk("R5 index 30 reads zero", v[63:32], 0);
    get(1'b0, 23, v); chk("R5 neighbour intact", v[31:0], 32'h2323_2323);
  endtask

  task automatic t_latency;
    @(negedge clk); reg_rd = 1; reg_sel = 2'd0;
    @(posedge clk); #1; reg_rd = 0;
    chk("R6 data one cycle after strobe", reg_rdata, 32'd23);
  endtask

  task automatic t_bist;
    logic [31:0] d;
    logic [63:0] v;
    wr(2'd0, 32'd20);
    wr(2'd3, 32'h1);
    repeat (26) @(negedge clk);
    wr(2'd1, 32'hDEAD_0000); wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd3, d); chk("R8 status while running", d, 32'h1);
    chk("R7 busy mid-run", d[0], 1);
    repeat (20) @(negedge clk);
    wr(2'd3, 32'h1);
    repeat (30) @(negedge clk);
    rd(2'd3, d); chk("R7 still busy before end", d[0], 1);
    repeat (12) @(negedge clk);
    rd(2'd3, d);
    chk("R7 start self-cleared, R8 R10 all pass", d, 32'h7E);
    get(1'b0, 0, v);  chk("R9 read buffer entry 0", v[31:0], 32'h5555_5555);
    get(1'b0, 20, v); chk("R9 R10 read buffer entry 20", v[63:32], 32'h5555_5555);
    get(1'b1, 23, v); chk("R9 write buffer entry 23 lo", v[31:0], 32'h5555_5555);
    chk("R9 write buffer entry 23 hi", v[63:32], 32'h5555_5555);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_index();
    t_stage_commit();
    t_separate();
    t_snapshot();
    t_invalid();
    t_latency();
    t_bist();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule